// File: doc/BRIEF.md
# Shared-Line Reset Supervisor

This block controls a single active-low, open-drain reset wire that serves two roles. It is the reset the block asserts toward the rest of the system, and it is also the input from a pushbutton that can pull the same wire low. The block combines three inputs into one reset sequence. The first is a digital power-fail indication from an external comparator. The second is an oscillator-ready indication. The third is a watchdog reset request. From these it produces the pull-down enable for the pad and an access-inhibit signal for the register bus interface.

A pushbutton press appears as a falling edge on the wire while the block is idle. The block then pulls the wire low for a debounce interval and lets it go. It waits for the wire to read high again, meaning the button has been released, and then issues the full reset pulse. All intervals are counted in ticks of a slow timebase enable, so the hold and debounce times are set by parameters, not by the fast clock.

Top module: `rst_supervisor`

## Requirements
- R1: While `pwr_fail` is 1, `line_drive_low` is 1 from the next clock onward, and `access_inhibit` is 1.
- R2: When `pwr_fail` returns to 0 with `osc_ready` at 1, `line_drive_low` stays 1 for exactly `HOLD_TICKS` ticks and then returns to 0.
- R3: When `pwr_fail` returns to 0 with `osc_ready` at 0, `line_drive_low` stays 1 for as long as `osc_ready` is 0. Once `osc_ready` rises, it stays 1 for a further `HOLD_TICKS` ticks.
- R4: In the idle state, a falling edge on the synchronized `line_in` starts a debounce in which `line_drive_low` is 1 for exactly `DEBOUNCE_TICKS` ticks and `access_inhibit` is 1.
- R5: After the debounce the wire is no longer driven. The block waits, with `access_inhibit` at 1, until `line_in` reads high, and then drives a `HOLD_TICKS` reset pulse. This also applies when the button was released during the debounce.
- R6: A `wdog_req` pulse in the idle state gives exactly one `HOLD_TICKS` low pulse, after which the wire is released and stays released.
- R7: `access_inhibit` is 1 whenever the block drives the wire or the synchronized wire reads low. In the idle state with the wire high it is 0.
- R8: The hold and debounce timers advance only in cycles where `tick` is 1. A driven interval never ends in a cycle without a tick.
- R9: `pwr_fail` overrides any pushbutton or watchdog sequence in progress. When it clears, the full `HOLD_TICKS` hold starts again from zero.
- R10: During `rst_n` low, `line_drive_low` and `access_inhibit` are both 1.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst_n | input | 1 | Asynchronous active-low logic reset |
| tick | input | 1 | Slow timebase enable, one cycle per tick |
| pwr_fail | input | 1 | Supply below threshold (digital comparator output) |
| osc_ready | input | 1 | Oscillator running and stable |
| wdog_req | input | 1 | Watchdog reset request pulse |
| line_in | input | 1 | Level read back from the shared reset wire |
| line_drive_low | output | 1 | Pull-down enable for the open-drain reset wire |
| access_inhibit | output | 1 | Blocks register access by the bus interface |

## Verification
The hardest case to reach is a button released while the block is still driving its own debounce pulse. The release cannot be seen on the wire at that moment, so the block has to pick it up as a rising edge only after it stops driving. The bench reproduces this by modelling the wire as the AND of the block's pull-down and a button switch, and by releasing the button one cycle into the debounce. A second hard case is a power failure in the middle of a watchdog pulse. The bench reaches it by raising `pwr_fail` partway through that pulse and then measuring that the whole hold restarts.

// File: rtl/rst_supervisor.sv
module rst_supervisor #(
  parameter int HOLD_TICKS     = 16,
  parameter int DEBOUNCE_TICKS = 4
) (
  input  logic clk,
  input  logic rst_n,
  input  logic tick,
  input  logic pwr_fail,
  input  logic osc_ready,
  input  logic wdog_req,
  input  logic line_in,
  output logic line_drive_low,
  output logic access_inhibit
);

  localparam int MAXT = (HOLD_TICKS > DEBOUNCE_TICKS) ? HOLD_TICKS : DEBOUNCE_TICKS;
  localparam int CW   = $clog2(MAXT + 1);
  localparam logic [CW-1:0] HOLD_LAST = CW'(HOLD_TICKS - 1);
  localparam logic [CW-1:0] DEB_LAST  = CW'(DEBOUNCE_TICKS - 1);

  typedef enum logic [2:0] {
    S_IDLE     = 3'd0,
    S_PFAIL    = 3'd1,
    S_WAIT_OSC = 3'd2,
    S_HOLD     = 3'd3,
    S_DEBOUNCE = 3'd4,
    S_WAIT_REL = 3'd5
  } st_t;

  st_t           st, st_nx;
  logic [CW-1:0] cnt;
  logic [2:0]    sync;

  wire line_s = sync[1];
  wire fell   = sync[2] & ~sync[1];
  wire rose   = ~sync[2] & sync[1];
  wire timing = (st == S_HOLD) || (st == S_DEBOUNCE);

  always_comb begin
    st_nx = st;
    if (pwr_fail) st_nx = S_PFAIL;
    else begin
      case (st)
        S_IDLE:     if (fell) st_nx = S_DEBOUNCE;
                    else if (wdog_req) st_nx = S_HOLD;
        S_PFAIL:    st_nx = osc_ready ? S_HOLD : S_WAIT_OSC;
        S_WAIT_OSC: if (osc_ready) st_nx = S_HOLD;
        S_HOLD:     if (tick && cnt == HOLD_LAST) st_nx = S_IDLE;
        S_DEBOUNCE: if (tick && cnt == DEB_LAST) st_nx = S_WAIT_REL;
        S_WAIT_REL: if (rose) st_nx = S_HOLD;
        default:    st_nx = S_PFAIL;
      endcase
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st   <= S_PFAIL;
      cnt  <= '0;
      sync <= 3'b111;
    end else begin
      st   <= st_nx;
      sync <= {sync[1:0], line_in};
      if (st_nx != st || st == S_PFAIL) cnt <= '0;
      else if (timing && tick)         cnt <= cnt + 1'b1;
    end
  end

  assign line_drive_low = (st == S_PFAIL) || (st == S_WAIT_OSC) || timing;
  assign access_inhibit = (st != S_IDLE) || !line_s;

endmodule

// File: rtl/rst_supervisor_chk.sv
module rst_supervisor_chk (
  input logic       clk,
  input logic       rst_n,
  input logic       tick,
  input logic       pwr_fail,
  input logic       osc_ready,
  input logic       wdog_req,
  input logic       line_drive_low,
  input logic       access_inhibit,
  input logic [2:0] st
);

  p_pfail_drive_r1: assert property (@(posedge clk) disable iff (!rst_n)
    pwr_fail |=> line_drive_low);

  p_osc_wait_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd2 && !osc_ready) |=> line_drive_low);

  p_wdog_pulse_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (st == 3'd0 && wdog_req) |=> line_drive_low);

  p_inhibit_r7: assert property (@(posedge clk) disable iff (!rst_n)
    line_drive_low |-> access_inhibit);

  p_no_tick_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (line_drive_low && !tick) |=> line_drive_low);

endmodule

bind rst_supervisor rst_supervisor_chk u_chk (
  .clk            (clk),
  .rst_n          (rst_n),
  .tick           (tick),
  .pwr_fail       (pwr_fail),
  .osc_ready      (osc_ready),
  .wdog_req       (wdog_req),
  .line_drive_low (line_drive_low),
  .access_inhibit (access_inhibit),
  .st             (st)
);

// File: tb/tb_rst_supervisor.sv
`timescale 1ns/1ps
module tb_rst_supervisor;
  localparam int H = 12;
  localparam int D = 5;

  logic clk = 0, rst_n = 0, tick = 1, pwr_fail = 0, osc_ready = 1, wdog_req = 0;
  logic button = 0;
  logic line_in, line_drive_low, access_inhibit;
  int   checks = 0, fails = 0;

  always #5 clk = ~clk;
  assign line_in = ~(line_drive_low | button);

  rst_supervisor #(.HOLD_TICKS(H), .DEBOUNCE_TICKS(D)) dut (
    .clk(clk), .rst_n(rst_n), .tick(tick), .pwr_fail(pwr_fail),
    .osc_ready(osc_ready), .wdog_req(wdog_req), .line_in(line_in),
    .line_drive_low(line_drive_low), .access_inhibit(access_inhibit));

  task automatic check(input bit ok, input string req, input int act, input int exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  task automatic run_len(output int n);
    n = 0;
    while (line_drive_low && n < 10000) begin n++; @(negedge clk); end
  endtask

  task automatic wait_drive();
    int g = 0;
    while (!line_drive_low && g < 1000) begin g++; @(negedge clk); end
  endtask

  task automatic idle_ok(input string req);
    check(line_drive_low == 0, req, line_drive_low, 0);
    check(access_inhibit == 0, req, access_inhibit, 0);
  endtask

  task automatic t_reset();
    int n;
    @(negedge clk);
    check(line_drive_low == 1, "R10", line_drive_low, 1);
    check(access_inhibit == 1, "R10", access_inhibit, 1);
    rst_n = 1;
    @(negedge clk);
    run_len(n);
    repeat (4) @(negedge clk);
    idle_ok("R7");
  endtask

  task automatic t_pfail();
    int n;
    pwr_fail = 1;
    @(negedge clk);
    check(line_drive_low == 1, "R1", line_drive_low, 1);
    check(access_inhibit == 1, "R1", access_inhibit, 1);
    repeat (10) @(negedge clk);
    pwr_fail = 0;
    @(negedge clk);
    run_len(n);
    check(n == H, "R2", n, H);
    repeat (4) @(negedge clk);
    idle_ok("R2");
  endtask

  task automatic t_osc();
    int n;
    pwr_fail = 1; osc_ready = 0;
    repeat (5) @(negedge clk);
    pwr_fail = 0;
    repeat (3 * H) @(negedge clk);
    check(line_drive_low == 1, "R3", line_drive_low, 1);
    osc_ready = 1;
    @(negedge clk);
    run_len(n);
    check(n == H, "R3", n, H);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_wdog();
    int n, extra;
    wdog_req = 1;
    @(negedge clk);
    wdog_req = 0;
    run_len(n);
    check(n == H, "R6", n, H);
    extra = 0;
    repeat (20) begin @(negedge clk); extra += line_drive_low; end
    check(extra == 0, "R6", extra, 0);
  endtask

  task automatic t_button_long();
    int n;
    button = 1;
    @(negedge clk);
    wait_drive();
    check(access_inhibit == 1, "R4", access_inhibit, 1);
    run_len(n);
    check(n == D, "R4", n, D);
    repeat (20) @(negedge clk);
    check(line_drive_low == 0, "R5", line_drive_low, 0);
    check(access_inhibit == 1, "R5", access_inhibit, 1);
    button = 0;
    @(negedge clk);
    wait_drive();
    run_len(n);
    check(n == H, "R5", n, H);
    repeat (4) @(negedge clk);
    idle_ok("R7");
  endtask

  task automatic t_button_short();
    int n;
    button = 1;
    @(negedge clk);
    wait_drive();
    @(negedge clk);
    button = 0;
    run_len(n);
    check(n == D - 1, "R5", n, D - 1);
    wait_drive();
    run_len(n);
    check(n == H, "R5", n, H);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_tick();
    int n;
    wdog_req = 1;
    @(negedge clk);
    wdog_req = 0;
    tick = 0;
    repeat (40) @(negedge clk);
    check(line_drive_low == 1, "R8", line_drive_low, 1);
    tick = 1;
    run_len(n);
    check(n == H, "R8", n, H);
    repeat (4) @(negedge clk);
  endtask

  task automatic t_priority();
    int n;
    wdog_req = 1;
    @(negedge clk);
    wdog_req = 0;
    repeat (5) @(negedge clk);
    pwr_fail = 1;
    repeat (3) @(negedge clk);
    pwr_fail = 0;
    @(negedge clk);
    run_len(n);
    check(n == H, "R9", n, H);
    repeat (4) @(negedge clk);
    idle_ok("R9");
  endtask

  initial begin
    t_reset();
    t_pfail();
    t_osc();
    t_wdog();
    t_button_long();
    t_button_short();
    t_tick();
    t_priority();
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end

  initial begin
    repeat (100000) @(posedge clk);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule